// File: doc/BRIEF.md
# Rolling Shutter Line Sequencer

This block drives the line-level timing of a rolling-shutter image sensor. On a frame start it pulses a read sync so the read shift chain loads its start pointer. It then counts line strobes. Once a programmed delay in lines has passed, it pulses a reset sync so the reset shift chain loads its own start pointer, and it marks that same cycle on a timeout output. Each line is exposed while other lines are being read. The exposure in lines is therefore the frame's line total minus the programmed delay.

The line total, the delay and the two start pointers are sampled on the frame start and held for the whole frame. The pointers are presented on outputs so that the shift chains can load them on the matching sync. In normal use the two pointers carry the same value. If the delay is not smaller than the line total, the reset sync is clamped to the last line, so it still fires once in every frame.

Top module: `rls_line_seq`

## Requirements
- R1: After reset, every sync output, the timeout output and both pointer outputs are 0.
- R2: When frame_start_i is sampled high on a rising edge, read_sync_o is high for exactly the next cycle. From that cycle on, rd_ptr_o shows the read pointer captured at that edge.
- R3: Take the effective delay T: T is 0 if the line total N is 0, N-1 if the delay D is at least N, and D otherwise. If T is nonzero, reset_sync_o is high for one cycle right after the edge that samples the T-th line strobe of the frame. If T is 0, it pulses in the same cycle as read_sync_o.
- R4: timeout_o is high in exactly the cycles in which reset_sync_o is high.
- R5: A delay at least as large as the line total is clamped to N-1. For N of 0 or 1 this means the reset sync fires together with the read sync.
- R6: The reset sync fires at most once per frame. Line strobes after the N-th strobe of a frame, and line strobes before the first frame start, cause no sync pulse.
- R7: Changes to the total, delay or pointer inputs between frame starts have no effect on pulse timing or on rd_ptr_o and rs_ptr_o until the next frame start.
- R8: A frame start during a frame restarts the line count from zero. A line strobe sampled on the same edge as a frame start is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame start strobe |
| line_i | input | 1 | One-cycle strobe per read line |
| total_lines_i | input | CNT_W | Lines in a frame |
| expo_delay_i | input | CNT_W | Lines from read sync to reset sync |
| rd_ptr_i | input | PTR_W | Start pointer for the read chain |
| rs_ptr_i | input | PTR_W | Start pointer for the reset chain |
| read_sync_o | output | 1 | Read-chain load pulse |
| reset_sync_o | output | 1 | Reset-chain load pulse |
| timeout_o | output | 1 | Marks the reset-sync cycle |
| rd_ptr_o | output | PTR_W | Held read pointer |
| rs_ptr_o | output | PTR_W | Held reset pointer |

## Verification
The bench targets a delay of zero, a delay equal to or above the line total, and line totals of 0 and 1. A design that got these wrong would miss the reset sync, fire it twice, or fire it on a line that never comes. It sends surplus line strobes past the frame end and strobes before any frame. A counter that kept running would then re-arm and pulse again. It changes the configuration mid-frame, which would shift the pulse in a design that did not hold its settings. It also restarts a frame with a coincident line strobe, which would bring the pulse one line early if that strobe were counted.

// File: rtl/rls_pkg.sv
package rls_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_INT  = 2'd2
    } phase_t;
endpackage

// File: rtl/rls_cfg.sv
module rls_cfg #(
    parameter int CNT_W = 12,
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    input  logic [PTR_W-1:0] rs_ptr_i,
    output logic [CNT_W-1:0] total_now_o,
    output logic [CNT_W-1:0] target_now_o,
    output logic [CNT_W-1:0] total_q_o,
    output logic [CNT_W-1:0] target_q_o,
    output logic [PTR_W-1:0] rd_ptr_q_o,
    output logic [PTR_W-1:0] rs_ptr_q_o
);
    typedef struct packed {
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] target;
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] rs_ptr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [CNT_W-1:0] clamp_w;

    always_comb begin
        if (total_i == '0) begin
            clamp_w = '0;
        end else if (delay_i >= total_i) begin
            clamp_w = total_i - 1'b1;
        end else begin
            clamp_w = delay_i;
        end
        cfg_d = cfg_q;
        if (frame_start_i) begin
            cfg_d.total  = total_i;
            cfg_d.target = clamp_w;
            cfg_d.rd_ptr = rd_ptr_i;
            cfg_d.rs_ptr = rs_ptr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign total_now_o  = total_i;
    assign target_now_o = clamp_w;
    assign total_q_o    = cfg_q.total;
    assign target_q_o   = cfg_q.target;
    assign rd_ptr_q_o   = cfg_q.rd_ptr;
    assign rs_ptr_q_o   = cfg_q.rs_ptr;

    // R7: held settings move only on a frame start
    assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(cfg_q));
    // R5: latched target is below the latched total unless the total is zero
    assert_target_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.total != '0) |-> (cfg_q.target < cfg_q.total));
endmodule

// File: rtl/rls_line_ctr.sv
module rls_line_ctr
    import rls_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             line_i,
    input  logic [CNT_W-1:0] total_now_i,
    input  logic [CNT_W-1:0] target_now_i,
    input  logic [CNT_W-1:0] total_q_i,
    input  logic [CNT_W-1:0] target_q_i,
    output logic             fire_o
);
    typedef struct packed {
        phase_t           phase;
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [CNT_W-1:0] inc_w;

    always_comb begin
        inc_w = ctr_q.cnt + 1'b1;
        ctr_d = ctr_q;
        ctr_d.fire = 1'b0;
        if (frame_start_i) begin
            ctr_d.cnt = '0;
            if (target_now_i == '0) begin
                ctr_d.fire  = 1'b1;
                ctr_d.phase = (total_now_i == '0) ? PH_IDLE : PH_INT;
            end else begin
                ctr_d.phase = PH_PRE;
            end
        end else if (line_i && (ctr_q.phase != PH_IDLE)) begin
            ctr_d.cnt = inc_w;
            if ((ctr_q.phase == PH_PRE) && (inc_w == target_q_i)) begin
                ctr_d.fire  = 1'b1;
                ctr_d.phase = PH_INT;
            end
            if (inc_w == total_q_i) begin
                ctr_d.phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '{phase: PH_IDLE, cnt: '0, fire: 1'b0};
        else        ctr_q <= ctr_d;
    end

    assign fire_o = ctr_q.fire;

    // R6: no second pulse inside the same frame
    assert_single_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.fire && !frame_start_i) |=> !ctr_q.fire);
    // R6: an idle counter neither counts nor fires without a frame start
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.phase == PH_IDLE && !frame_start_i) |=> (!ctr_q.fire && $stable(ctr_q.cnt)));
    // R8: a frame start clears the line count
    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (ctr_q.cnt == '0));
    // R3: a pulse follows only a frame start or a line strobe
    assert_fire_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctr_q.fire) |-> ($past(frame_start_i) || $past(line_i)));
endmodule

// File: rtl/rls_line_seq.sv
module rls_line_seq
    import rls_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             line_i,
    input  logic [CNT_W-1:0] total_lines_i,
    input  logic [CNT_W-1:0] expo_delay_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    input  logic [PTR_W-1:0] rs_ptr_i,
    output logic             read_sync_o,
    output logic             reset_sync_o,
    output logic             timeout_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [PTR_W-1:0] rs_ptr_o
);
    logic [CNT_W-1:0] total_now_w, target_now_w, total_q_w, target_q_w;
    logic             fire_w;

    typedef struct packed {
        logic read_sync;
    } out_t;
    out_t out_d, out_q;

    rls_cfg #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start_i),
        .total_i      (total_lines_i),
        .delay_i      (expo_delay_i),
        .rd_ptr_i     (rd_ptr_i),
        .rs_ptr_i     (rs_ptr_i),
        .total_now_o  (total_now_w),
        .target_now_o (target_now_w),
        .total_q_o    (total_q_w),
        .target_q_o   (target_q_w),
        .rd_ptr_q_o   (rd_ptr_o),
        .rs_ptr_q_o   (rs_ptr_o)
    );

    rls_line_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start_i),
        .line_i       (line_i),
        .total_now_i  (total_now_w),
        .target_now_i (target_now_w),
        .total_q_i    (total_q_w),
        .target_q_i   (target_q_w),
        .fire_o       (fire_w)
    );

    always_comb begin
        out_d = out_q;
        out_d.read_sync = frame_start_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign read_sync_o  = out_q.read_sync;
    assign reset_sync_o = fire_w;
    assign timeout_o    = fire_w;

    // R2: each sampled frame start yields a read sync on the next cycle
    assert_read_sync_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_start_i) && $past(rst_n)) |-> read_sync_o);
    // R2: a read sync without a preceding frame start is illegal
    assert_read_sync_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_sync_o) |-> $past(frame_start_i));
    // R3: a zero effective delay puts both syncs in the same cycle
    assert_zero_delay_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && target_now_w == '0) |=> (read_sync_o && reset_sync_o));
endmodule

// File: tb/tb_rls_line_seq.sv
module tb_rls_line_seq;
    localparam int CNT_W = 12;
    localparam int PTR_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start_i = 1'b0;
    logic             line_i = 1'b0;
    logic [CNT_W-1:0] total_lines_i = '0;
    logic [CNT_W-1:0] expo_delay_i = '0;
    logic [PTR_W-1:0] rd_ptr_i = '0;
    logic [PTR_W-1:0] rs_ptr_i = '0;
    logic             read_sync_o, reset_sync_o, timeout_o;
    logic [PTR_W-1:0] rd_ptr_o, rs_ptr_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    rls_line_seq #(.CNT_W(CNT_W), .PTR_W(PTR_W)) dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_delay(input int n, input int d);
        if (n == 0) return 0;
        if (d >= n) return n - 1;
        return d;
    endfunction

    // drives a frame start at a negedge, checks outputs one cycle later
    task automatic start_frame(input int n, input int d, input int rp, input int sp,
                               input bit with_line);
        int t;
        t = eff_delay(n, d);
        @(negedge clk);
        total_lines_i = CNT_W'(n); expo_delay_i = CNT_W'(d);
        rd_ptr_i = PTR_W'(rp); rs_ptr_i = PTR_W'(sp);
        frame_start_i = 1'b1; line_i = with_line;
        @(negedge clk);
        frame_start_i = 1'b0; line_i = 1'b0;
        chk("R2 read_sync", int'(read_sync_o), 1);
        chk("R2 rd_ptr", int'(rd_ptr_o), rp);
        chk("R7 rs_ptr", int'(rs_ptr_o), sp);
        chk("R3 reset_sync at start", int'(reset_sync_o), (t == 0) ? 1 : 0);
        chk("R4 timeout at start", int'(timeout_o), int'(reset_sync_o));
    endtask

    // one line strobe; returns the reset_sync seen after it
    task automatic strobe(output int got);
        line_i = 1'b1;
        @(negedge clk);
        line_i = 1'b0;
        got = int'(reset_sync_o);
        chk("R4 timeout tracks reset_sync", int'(timeout_o), got);
        chk("R2 read_sync single", int'(read_sync_o), 0);
    endtask

    task automatic run_frame(input string req, input int n, input int d, input int extra);
        int t, got, pulses;
        t = eff_delay(n, d);
        start_frame(n, d, 37, 37, 1'b0);
        pulses = (t == 0) ? 1 : 0;
        for (int k = 1; k <= n + extra; k++) begin
            strobe(got);
            pulses += got;
            chk(req, got, (t != 0 && k == t) ? 1 : 0);
        end
        chk("R6 one pulse per frame", pulses, 1);
    endtask

    task automatic test_reset_state();
        chk("R1 read_sync", int'(read_sync_o), 0);
        chk("R1 reset_sync", int'(reset_sync_o), 0);
        chk("R1 timeout", int'(timeout_o), 0);
        chk("R1 rd_ptr", int'(rd_ptr_o), 0);
        chk("R1 rs_ptr", int'(rs_ptr_o), 0);
    endtask

    task automatic test_no_frame_yet();
        int got;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            strobe(got);
            chk("R6 strobe before frame", got, 0);
        end
    endtask

    task automatic test_midframe_change();
        int got;
        start_frame(6, 2, 100, 200, 1'b0);
        total_lines_i = 12'd3; expo_delay_i = 12'd1;
        rd_ptr_i = 10'd5; rs_ptr_i = 10'd6;
        for (int k = 1; k <= 7; k++) begin
            strobe(got);
            chk("R7 held delay", got, (k == 2) ? 1 : 0);
            chk("R7 held rd_ptr", int'(rd_ptr_o), 100);
            chk("R7 held rs_ptr", int'(rs_ptr_o), 200);
        end
    endtask

    task automatic test_restart();
        int got;
        start_frame(10, 4, 1, 1, 1'b0);
        for (int k = 1; k <= 2; k++) begin
            strobe(got);
            chk("R8 before restart", got, 0);
        end
        start_frame(10, 3, 2, 2, 1'b1);
        for (int k = 1; k <= 5; k++) begin
            strobe(got);
            chk("R8 count restarted", got, (k == 3) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset_state();
        rst_n = 1'b1;
        test_no_frame_yet();
        run_frame("R3 delay 2 of 6", 6, 2, 3);
        run_frame("R3 delay 7 of 8", 8, 7, 2);
        run_frame("R3 zero delay", 5, 0, 2);
        run_frame("R5 clamp delay 9 of 4", 4, 9, 3);
        run_frame("R5 clamp delay equal total", 5, 5, 2);
        run_frame("R5 total 1", 1, 5, 3);
        run_frame("R5 total 0", 0, 3, 3);
        test_midframe_change();
        test_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule